// File: doc/BRIEF.md
# Winding Open-Load Detector

This block watches the two coils of a stepper driver for a broken or missing winding. Each coil supplies two comparator results: current below the open-load threshold, and current below the regulation trip level. A coil is suspect only while both are asserted together and detection is enabled. A per-coil persistence timer counts consecutive suspect cycles. When the run is longer than the configured detection time, that coil's sticky open-load bit is set.

A set bit raises the shared fault request and pulls the active-low fault pin low. It stays set after the coil current comes back. It is released by a clear-faults strobe or a sleep-reset pulse, and only when that coil's undercurrent condition has gone. Leaving sleep, or a full reset, clears everything unconditionally.

If a position holds one coil's target current at zero for longer than the detection time, that coil reads as open. This is expected and correct. Full-step operation never produces a zero coil target.

Top module: `olDetTop`

## Requirements
- R1: While `rstN` is low and on release, `olA` and `olB` are 0, `olAny` and `faultReq` are 0, and `faultPinN` is 1.
- R2: A coil's bit sets after the clock edge on which both of its undercurrent inputs and `olEnable` have been sampled high on DETECT_CYCLES+1 consecutive edges. It stays clear for DETECT_CYCLES or fewer such edges.
- R3: Any edge on which either undercurrent input of a coil is low restarts that coil's persistence count from zero. One input alone never sets the bit.
- R4: While `olEnable` is 0, no bit sets and the persistence counts restart. Bits already set stay set.
- R5: Coil A inputs affect only `olA`, and coil B inputs affect only `olB`.
- R6: A set bit remains 1 after the undercurrent inputs return low, until a clear event.
- R7: A `clearFaults` or `sleepResetPulse` strobe clears a coil's bit on the next edge if that coil's two undercurrent inputs are not both high. While both are high, the bit stays 1.
- R8: `sleepExit` clears both bits and both persistence counts on the next edge, regardless of inputs. A held condition must then persist again for DETECT_CYCLES+1 edges.
- R9: `olAny` and `faultReq` equal `olA | olB`, and `faultPinN` is its inverse, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset (power cycle) |
| olEnable | input | 1 | Detection enable |
| aBelowOl | input | 1 | Coil A current below open-load threshold |
| aBelowTrip | input | 1 | Coil A current below regulation trip level |
| bBelowOl | input | 1 | Coil B current below open-load threshold |
| bBelowTrip | input | 1 | Coil B current below regulation trip level |
| clearFaults | input | 1 | Clear-faults strobe |
| sleepResetPulse | input | 1 | Sleep-reset pulse, acts as a clear |
| sleepExit | input | 1 | Exit-from-sleep event, unconditional clear |
| olA | output | 1 | Sticky open-load flag, coil A |
| olB | output | 1 | Sticky open-load flag, coil B |
| olAny | output | 1 | Open-load summary |
| faultReq | output | 1 | Contribution to the device fault bit |
| faultPinN | output | 1 | Fault pin drive, low while any bit is set |

## Verification
Several rules are checked as clocked properties on every cycle. A bit never rises without its condition present and enabled on that edge. A rising bit always follows a full run of DETECT_CYCLES+1 suspect samples, counted independently in the checker. Bits hold unless cleared. An allowed clear or a sleep exit takes effect on the next edge. Three things only the bench scenarios can show: the exact boundary between N and N+1 samples, the independence of the two coils across all input combinations, and the restart of a count after an interruption or sleep exit.

// File: rtl/olDetPkg.sv
package olDetPkg;
  localparam int NUM_WIND = 2;

  // strobes from control to datapath, one lane per winding
  typedef struct packed {
    logic [NUM_WIND-1:0] runTimer;  // winding suspect this cycle
    logic [NUM_WIND-1:0] clrBit;    // sticky bit may be cleared
    logic                flush;     // unconditional wipe (sleep exit)
  } ctrlStrobes_t;
endpackage

// File: rtl/olCtrl.sv
module olCtrl
  import olDetPkg::*;
(
  input  logic                enable,
  input  logic [NUM_WIND-1:0] belowOl,
  input  logic [NUM_WIND-1:0] belowTrip,
  input  logic                clearFaults,
  input  logic                sleepResetPulse,
  input  logic                sleepExit,
  output ctrlStrobes_t        strb
);
  logic [NUM_WIND-1:0] rawCond;
  logic                clearReq;

  assign clearReq = clearFaults | sleepResetPulse;

  always_comb begin
    strb = '0;
    strb.flush = sleepExit;
    for (int i = 0; i < NUM_WIND; i++) begin
      rawCond[i]       = belowOl[i] & belowTrip[i];
      strb.runTimer[i] = enable & rawCond[i];
      // a requested clear is honoured only once the condition is gone
      strb.clrBit[i]   = sleepExit | (clearReq & ~rawCond[i]);
    end
  end
endmodule

// File: rtl/olDatapath.sv
module olDatapath
  import olDetPkg::*;
#(
  parameter int DETECT_CYCLES = 1000
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strb,
  output logic [NUM_WIND-1:0] olBits
);
  localparam int CNT_W = $clog2(DETECT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DETECT_CYCLES);

  for (genvar w = 0; w < NUM_WIND; w++) begin : gWind
    logic [CNT_W-1:0] persistCnt;
    logic             hit;

    assign hit = strb.runTimer[w] && (persistCnt == LIMIT) && !strb.flush;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        persistCnt <= '0;
      end else if (strb.flush || !strb.runTimer[w]) begin
        persistCnt <= '0;
      end else if (persistCnt != LIMIT) begin
        persistCnt <= persistCnt + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        olBits[w] <= 1'b0;
      end else if (strb.flush) begin
        olBits[w] <= 1'b0;
      end else if (hit) begin
        olBits[w] <= 1'b1;
      end else if (strb.clrBit[w]) begin
        olBits[w] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/olDetTop.sv
module olDetTop
  import olDetPkg::*;
#(
  parameter int DETECT_CYCLES = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic olEnable,
  input  logic aBelowOl,
  input  logic aBelowTrip,
  input  logic bBelowOl,
  input  logic bBelowTrip,
  input  logic clearFaults,
  input  logic sleepResetPulse,
  input  logic sleepExit,
  output logic olA,
  output logic olB,
  output logic olAny,
  output logic faultReq,
  output logic faultPinN
);
  ctrlStrobes_t        strb;
  logic [NUM_WIND-1:0] olBits;

  olCtrl uCtrl (
    .enable         (olEnable),
    .belowOl        ({bBelowOl, aBelowOl}),
    .belowTrip      ({bBelowTrip, aBelowTrip}),
    .clearFaults    (clearFaults),
    .sleepResetPulse(sleepResetPulse),
    .sleepExit      (sleepExit),
    .strb           (strb)
  );

  olDatapath #(.DETECT_CYCLES(DETECT_CYCLES)) uPath (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .olBits(olBits)
  );

  assign olA       = olBits[0];
  assign olB       = olBits[1];
  assign olAny     = |olBits;
  assign faultReq  = |olBits;
  assign faultPinN = ~(|olBits);
endmodule

// File: rtl/olDetChecker.sv
module olDetChecker #(
  parameter int DETECT_CYCLES = 1000
) (
  input logic clk,
  input logic rstN,
  input logic olEnable,
  input logic aBelowOl,
  input logic aBelowTrip,
  input logic bBelowOl,
  input logic bBelowTrip,
  input logic clearFaults,
  input logic sleepResetPulse,
  input logic sleepExit,
  input logic olA,
  input logic olB,
  input logic olAny,
  input logic faultReq,
  input logic faultPinN
);
  localparam int RW = $clog2(DETECT_CYCLES + 2) + 1;
  localparam logic [RW-1:0] SAT = RW'(DETECT_CYCLES + 1);

  logic suspA, suspB, clrReq;
  logic [RW-1:0] runA, runB;

  assign suspA  = olEnable && aBelowOl && aBelowTrip;
  assign suspB  = olEnable && bBelowOl && bBelowTrip;
  assign clrReq = clearFaults || sleepResetPulse;

  // independent run-length of suspect samples, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runA <= '0;
      runB <= '0;
    end else begin
      runA <= !suspA ? '0 : (runA == SAT ? runA : runA + 1'b1);
      runB <= !suspB ? '0 : (runB == SAT ? runB : runB + 1'b1);
    end
  end

  assert_set_needs_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(olA) |-> (runA == SAT));
  assert_set_needs_run_b_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(olB) |-> (runB == SAT));

  assert_no_set_disabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    !olEnable |=> !$rose(olA) && !$rose(olB));

  assert_single_flag_no_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(aBelowOl && aBelowTrip) |=> !$rose(olA));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (olA && !clrReq && !sleepExit) |=> olA);

  assert_clear_allowed_R7: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !(aBelowOl && aBelowTrip)) |=> !olA);

  assert_clear_blocked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (olB && clrReq && bBelowOl && bBelowTrip && !sleepExit) |=> olB);

  assert_sleep_exit_R8: assert property (@(posedge clk) disable iff (!rstN)
    sleepExit |=> !olA && !olB && faultPinN && !olAny && !faultReq);

  assert_pin_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(olA) |-> !faultPinN && olAny && faultReq);
endmodule

bind olDetTop olDetChecker #(.DETECT_CYCLES(DETECT_CYCLES)) uChk (
  .clk(clk), .rstN(rstN), .olEnable(olEnable),
  .aBelowOl(aBelowOl), .aBelowTrip(aBelowTrip),
  .bBelowOl(bBelowOl), .bBelowTrip(bBelowTrip),
  .clearFaults(clearFaults), .sleepResetPulse(sleepResetPulse),
  .sleepExit(sleepExit), .olA(olA), .olB(olB), .olAny(olAny),
  .faultReq(faultReq), .faultPinN(faultPinN)
);

// File: tb/tb_olDetTop.sv
`timescale 1ns/1ps
module tb_olDetTop;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic olEnable = 1'b0;
  logic aBelowOl = 1'b0, aBelowTrip = 1'b0, bBelowOl = 1'b0, bBelowTrip = 1'b0;
  logic clearFaults = 1'b0, sleepResetPulse = 1'b0, sleepExit = 1'b0;
  logic olA, olB, olAny, faultReq, faultPinN;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  olDetTop #(.DETECT_CYCLES(N)) dut (
    .clk(clk), .rstN(rstN), .olEnable(olEnable),
    .aBelowOl(aBelowOl), .aBelowTrip(aBelowTrip),
    .bBelowOl(bBelowOl), .bBelowTrip(bBelowTrip),
    .clearFaults(clearFaults), .sleepResetPulse(sleepResetPulse),
    .sleepExit(sleepExit), .olA(olA), .olB(olB), .olAny(olAny),
    .faultReq(faultReq), .faultPinN(faultPinN)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setA(input logic v);
    aBelowOl = v; aBelowTrip = v;
  endtask

  task automatic setB(input logic v);
    bBelowOl = v; bBelowTrip = v;
  endtask

  task automatic wipe();
    setA(0); setB(0);
    sleepExit = 1'b1; tick(1); sleepExit = 1'b0;
  endtask

  task automatic checkSummary(input string tag);
    chk({tag, " olAny"}, olAny, olA | olB);
    chk({tag, " faultReq"}, faultReq, olA | olB);
    chk({tag, " faultPinN"}, faultPinN, ~(olA | olB));
  endtask

  initial begin
    tick(3);
    chk("R1 reset olA", olA, 1'b0);
    chk("R1 reset olB", olB, 1'b0);
    chk("R1 reset pin", faultPinN, 1'b1);
    rstN = 1'b1;
    olEnable = 1'b1;
    tick(1);
    chk("R1 after release olAny", olAny, 1'b0);

    // R2 boundary sweep, coil A then coil B (R5 cross-check)
    for (int k = 0; k <= N + 3; k++) begin
      setA(1); tick(k); setA(0);
      chk($sformatf("R2 A hold=%0d", k), olA, k >= N + 1);
      chk($sformatf("R5 B quiet hold=%0d", k), olB, 1'b0);
      checkSummary("R9 sweepA");
      wipe();
    end
    for (int k = 0; k <= N + 3; k++) begin
      setB(1); tick(k); setB(0);
      chk($sformatf("R2 B hold=%0d", k), olB, k >= N + 1);
      chk($sformatf("R5 A quiet hold=%0d", k), olA, 1'b0);
      wipe();
    end

    // exhaustive input combinations: R3 R4 R5 R9
    for (int c = 0; c < 32; c++) begin
      olEnable = c[4];
      aBelowOl = c[0]; aBelowTrip = c[1]; bBelowOl = c[2]; bBelowTrip = c[3];
      tick(N + 3);
      chk($sformatf("R3 R4 combo %0d A", c), olA, c[4] & c[0] & c[1]);
      chk($sformatf("R3 R4 R5 combo %0d B", c), olB, c[4] & c[2] & c[3]);
      checkSummary($sformatf("R9 combo %0d", c));
      wipe();
    end
    olEnable = 1'b1;

    // R3 interruption restarts the count
    setA(1); tick(N); aBelowTrip = 0; tick(1); aBelowTrip = 1; tick(N);
    chk("R3 interrupted run", olA, 1'b0);
    tick(1);
    chk("R3 fresh full run", olA, 1'b1);
    wipe();

    // R4 enable low keeps latched bit, restarts count
    setA(1); tick(N + 1);
    olEnable = 0; tick(3);
    chk("R4 latched kept", olA, 1'b1);
    setB(1); tick(N + 3);
    chk("R4 disabled no set B", olB, 1'b0);
    olEnable = 1; tick(N);
    chk("R4 count restarted", olB, 1'b0);
    tick(1);
    chk("R4 set after reenable", olB, 1'b1);
    wipe();

    // R6 sticky, R7 clear blocked then allowed
    setA(1); tick(N + 1);
    clearFaults = 1; tick(1); clearFaults = 0;
    chk("R7 clear blocked", olA, 1'b1);
    setA(0); tick(10);
    chk("R6 sticky", olA, 1'b1);
    chk("R9 pin low", faultPinN, 1'b0);
    clearFaults = 1; tick(1); clearFaults = 0;
    chk("R7 clearFaults", olA, 1'b0);
    chk("R9 pin released", faultPinN, 1'b1);

    // R7 sleep-reset pulse per coil
    setA(1); setB(1); tick(N + 1);
    setB(0);
    sleepResetPulse = 1; tick(1); sleepResetPulse = 0;
    chk("R7 pulse clears B", olB, 1'b0);
    chk("R7 pulse blocked A", olA, 1'b1);
    wipe();

    // R8 sleep exit with condition held
    setA(1); tick(N + 1);
    chk("R8 preset", olA, 1'b1);
    sleepExit = 1; tick(1); sleepExit = 0;
    chk("R8 cleared", olA, 1'b0);
    tick(N);
    chk("R8 count restarted", olA, 1'b0);
    tick(1);
    chk("R8 set again", olA, 1'b1);
    wipe();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule